// File: doc/BRIEF.md
# Settling-Filtered Programmable Clock Divider

This block derives a square wave from a master clock. A 4-bit selection code sets both the division ratio and the output polarity. The code input is sampled on every cycle. A new value is taken up only after it has stayed unchanged for a wait that grows with the value itself, so a noisy or slowly settling code source never moves the output. The divider changes ratio only at the boundary of a complete output period. As a result, the waveform has no runt or glitch pulse when the ratio changes.

After reset the output stays low. It stays low until a fixed power-up hold has run out and a first code has passed the settling filter. It then toggles with a 50% duty cycle. A status output reports the code that the divider is currently using, and a flag marks that a code has been accepted.

Top module: `fcode_clkdiv`

## Requirements
- R1: After reset is released, `div_o` stays low for at least START_CYC (500) master clock cycles.
- R2: `div_o` stays low for as long as no code has passed the settling filter, even once the power-up hold has ended.
- R3: A code is accepted only after the synchronized input has held it for SETTLE_MUL × (code + SETTLE_OFS) cycles (16 × (code + 6)). While the ratio-1 setting is in use, the new code appears on `applied_code_o` no later than 8 cycles after that minimum.
- R4: Any change of the input during the settling wait restarts the wait, so a code held for less than its own wait is never accepted.
- R5: `applied_code_o` moves directly from the old accepted code to the new one. It never shows a code that was present only briefly or that lay between the two.
- R6: Let the exponent be e = code for codes 0–7 and e = 15 − code for codes 8–15. The ratio is 4^e. For ratios of 4 and above, `div_o` is high for ratio/2 cycles and low for ratio/2 cycles.
- R7: With ratio 1, `div_o` follows the master clock: it equals `clk_i` for code 0 and the inverse of `clk_i` for code 15.
- R8: A ratio change takes effect only at the end of a full output period. When the new code has the same polarity bit (bit 3) as the old one, every high or low interval equals either the old half-period or the new one.
- R9: Code bit 3 set selects inverted polarity. With normal polarity, the first high pulse after start-up has full nominal width. With inverted polarity, that first high pulse is never shorter than a quarter of the output period.
- R10: `applied_code_o` reports the code the divider is using, and `applied_valid_o` rises once the first code has been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_i | input | 4 | Raw selection code, may be asynchronous |
| div_o | output | 1 | Divided output |
| applied_code_o | output | 4 | Code currently driving the divider |
| applied_valid_o | output | 1 | A code has been accepted |

## Verification
Several properties are checked on every cycle:
- the enable never rises before the hold counter expires or before a code is accepted, and once set it never drops;
- the accepted code only ever takes a value that the candidate register held through its full wait;
- the code in use changes only at a period boundary;
- the half-period counter never passes its limit.

Other behaviours can only be shown by the bench's directed scenarios. These are the measured high and low widths at several ratios and both polarities, the exact settling latency and its restart on a code bounce, the inversion of the master clock at ratio 1, and the absence of short pulses across a live ratio switch.

// File: rtl/fcode_clkdiv.sv
module fcode_clkdiv #(
  parameter int START_CYC  = 500,
  parameter int SETTLE_MUL = 16,
  parameter int SETTLE_OFS = 6,
  parameter int MAX_EXP    = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [3:0]           code_i,
  output logic                 div_o,
  output logic [3:0]           applied_code_o,
  output logic                 applied_valid_o
);
  localparam int EXP_W    = $clog2(MAX_EXP + 1);
  localparam int CODE_W   = EXP_W + 1;
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int HCNT_W   = 2 * MAX_EXP;
  localparam int TMR_W    = $clog2(START_CYC + 1);
  localparam int SCNT_W   = $clog2(SETTLE_MUL * (CODE_MAX + SETTLE_OFS) + 1);

  logic [CODE_W-1:0] sync1_q, sync2_q, cand_q, filt_q, applied_q;
  logic [SCNT_W-1:0] scnt_q, lim;
  logic [TMR_W-1:0]  tmr_q;
  logic [HCNT_W-1:0] hcnt_q, half_m1;
  logic              valid_q, run_q, phase_q;
  logic              pol, bypass, tmr_done;
  logic [EXP_W-1:0]  expo;

  assign pol      = applied_q[CODE_W-1];
  assign expo     = pol ? ~applied_q[EXP_W-1:0] : applied_q[EXP_W-1:0];
  assign bypass   = (expo == '0);
  assign half_m1  = HCNT_W'(((32'd1 << (2 * int'(expo))) >> 1) - 32'd1);
  assign lim      = SCNT_W'(SETTLE_MUL * (int'(cand_q) + SETTLE_OFS));
  assign tmr_done = (int'(tmr_q) == START_CYC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
      cand_q  <= '0;
      scnt_q  <= '0;
      filt_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      sync1_q <= code_i;
      sync2_q <= sync1_q;
      if (sync2_q != cand_q) begin
        cand_q <= sync2_q;
        scnt_q <= SCNT_W'(1);
      end else if (scnt_q != lim) begin
        scnt_q <= scnt_q + 1'b1;
      end
      if (scnt_q == lim) begin
        filt_q  <= cand_q;
        valid_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q     <= '0;
      run_q     <= 1'b0;
      phase_q   <= 1'b1;
      hcnt_q    <= '0;
      applied_q <= '0;
    end else begin
      if (!tmr_done) tmr_q <= tmr_q + 1'b1;
      if (!run_q && tmr_done && valid_q) run_q <= 1'b1;
      if (!run_q || bypass) begin
        applied_q <= filt_q;
        phase_q   <= 1'b1;
        hcnt_q    <= '0;
      end else if (hcnt_q == half_m1) begin
        hcnt_q  <= '0;
        phase_q <= ~phase_q;
        if (!phase_q) applied_q <= filt_q;
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  assign div_o           = run_q & (bypass ? (clk_i ^ pol) : (phase_q ^ pol));
  assign applied_code_o  = applied_q;
  assign applied_valid_o = valid_q;
endmodule

// File: rtl/fcode_clkdiv_chk.sv
module fcode_clkdiv_chk #(
  parameter int CODE_W = 4,
  parameter int HCNT_W = 14,
  parameter int SCNT_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tmr_done_i,
  input logic              run_i,
  input logic              valid_i,
  input logic              bypass_i,
  input logic              phase_i,
  input logic [CODE_W-1:0] cand_i,
  input logic [CODE_W-1:0] filt_i,
  input logic [CODE_W-1:0] applied_i,
  input logic [SCNT_W-1:0] scnt_i,
  input logic [SCNT_W-1:0] lim_i,
  input logic [HCNT_W-1:0] hcnt_i,
  input logic [HCNT_W-1:0] half_m1_i
);
  assert_hold_before_run_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_done_i |-> !run_i);

  assert_run_needs_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> valid_i);

  assert_run_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> run_i);

  assert_filt_after_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_i) |-> (filt_i == $past(cand_i)) && ($past(scnt_i) == $past(lim_i)));

  assert_wait_bounded_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scnt_i <= lim_i);

  assert_direct_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(applied_i) |-> applied_i == $past(filt_i));

  assert_switch_at_boundary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$stable(applied_i)) |->
      ($past(bypass_i) || (!$past(phase_i) && ($past(hcnt_i) == $past(half_m1_i)))));

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !bypass_i) |-> hcnt_i <= half_m1_i);
endmodule

bind fcode_clkdiv fcode_clkdiv_chk #(
  .CODE_W(CODE_W), .HCNT_W(HCNT_W), .SCNT_W(SCNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tmr_done_i(tmr_done), .run_i(run_q),
  .valid_i(valid_q), .bypass_i(bypass), .phase_i(phase_q), .cand_i(cand_q),
  .filt_i(filt_q), .applied_i(applied_q), .scnt_i(scnt_q), .lim_i(lim),
  .hcnt_i(hcnt_q), .half_m1_i(half_m1)
);

// File: tb/fcode_clkdiv_tb_top.sv
`timescale 1ns/100ps
module fcode_clkdiv_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] code = 4'd0;
  logic       div;
  logic [3:0] applied;
  logic       valid;
  int         checks = 0;
  int         errors = 0;

  always #2.5 clk = ~clk;

  fcode_clkdiv dut_i (
    .clk_i(clk), .rst_ni(rst_n), .code_i(code),
    .div_o(div), .applied_code_o(applied), .applied_valid_o(valid)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] c);
    rst_n = 1'b0;
    code  = c;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic wait_level(input bit v, input int tmo);
    for (int i = 0; i < tmo && div != v; i++) step();
  endtask

  task automatic run_len(input bit v, output int n);
    n = 0;
    while (div == v && n < 20000) begin
      n++;
      step();
    end
  endtask

  task automatic wait_applied(input logic [3:0] c, input int tmo, output int n);
    n = 0;
    while (applied != c && n < tmo) begin
      n++;
      step();
    end
  endtask

  function automatic int half_of(input logic [3:0] c);
    int e = c[3] ? 15 - int'(c) : int'(c);
    return (1 << (2 * e)) / 2;
  endfunction

  task automatic t_startup();
    int bad = 0, hi, lo;
    do_reset(4'd1);
    chk(div == 1'b0 && valid == 1'b0, "R1 reset state", int'(div), 0);
    for (int i = 0; i < 500; i++) begin
      step();
      if (div) bad++;
    end
    chk(bad == 0, "R1 low during hold", bad, 0);
    wait_level(1'b1, 200);
    run_len(1'b1, hi);
    run_len(1'b0, lo);
    chk(hi == 2, "R9 first pulse full width", hi, 2);
    chk(lo == 2, "R6 ratio 4 low width", lo, 2);
    chk(applied == 4'd1 && valid, "R10 applied code", int'(applied), 1);
  endtask

  task automatic t_ratio(input logic [3:0] c);
    int n, hi, lo, h;
    h = half_of(c);
    code = c;
    wait_applied(c, 30000, n);
    chk(applied == c, "R10 code taken up", int'(applied), int'(c));
    wait_level(1'b0, 20000);
    wait_level(1'b1, 20000);
    run_len(1'b1, hi);
    run_len(1'b0, lo);
    chk(hi == h, "R6 high width", hi, h);
    chk(lo == h, "R6 low width", lo, h);
  endtask

  task automatic t_bypass_pol(input logic [3:0] c, input bit inv);
    int bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      if (div != (1'b1 ^ inv)) bad++;
      #2.5;
      if (div != (1'b0 ^ inv)) bad++;
    end
    chk(bad == 0, inv ? "R9 R7 inverted clock" : "R7 clock passthrough", bad, int'(c) * 0);
  endtask

  task automatic t_settle();
    int n;
    code = 4'd0;
    wait_applied(4'd0, 30000, n);
    t_bypass_pol(4'd0, 1'b0);
    code = 4'd15;
    wait_applied(4'd15, 2000, n);
    chk(n >= 336 && n <= 344, "R3 settle latency code 15", n, 340);
    t_bypass_pol(4'd15, 1'b1);
  endtask

  task automatic t_restart();
    int n, bad = 0;
    code = 4'd0;
    for (int i = 0; i < 90; i++) begin
      step();
      if (applied != 4'd15) bad++;
    end
    code = 4'd14;
    n = 0;
    while (applied != 4'd14 && n < 2000) begin
      n++;
      step();
      if (applied != 4'd15 && applied != 4'd14) bad++;
    end
    chk(bad == 0, "R4 R5 bounce ignored", bad, 0);
    chk(n >= 320 && n <= 328, "R4 wait restarted code 14", n, 324);
  endtask

  task automatic t_switch(input logic [3:0] to, input int cyc);
    int bad = 0, len = 0;
    bit first = 1'b1, prev;
    code = to;
    prev = div;
    for (int i = 0; i < cyc; i++) begin
      step();
      if (div == prev) len++;
      else begin
        if (!first && len != 2 && len != 32) bad++;
        first = 1'b0;
        prev  = div;
        len   = 1;
      end
    end
    chk(bad == 0, "R8 no runt on switch", bad, 0);
    chk(applied == to, "R8 switch done", int'(applied), int'(to));
  endtask

  task automatic t_pol1_start();
    int hi;
    do_reset(4'd13);
    wait_level(1'b1, 1000);
    run_len(1'b1, hi);
    chk(hi >= 4, "R9 inverted first pulse", hi, 8);
  endtask

  task automatic t_no_code();
    int bad = 0, n;
    rst_n = 1'b0;
    code  = 4'd5;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 70; i++) begin
      code = (i % 2 == 1) ? 4'd5 : 4'd6;
      for (int j = 0; j < 10; j++) begin
        step();
        if (div || valid) bad++;
      end
    end
    code = 4'd1;
    for (int i = 0; i < 100; i++) begin
      step();
      if (div) bad++;
    end
    chk(bad == 0, "R2 low without code", bad, 0);
    wait_applied(4'd1, 200, n);
    wait_level(1'b1, 200);
    chk(div == 1'b1 && applied == 4'd1, "R2 starts after code", int'(div), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_startup();
    t_ratio(4'd2);
    t_ratio(4'd13);
    t_ratio(4'd10);
    t_ratio(4'd6);
    t_settle();
    t_restart();
    code = 4'd1;
    begin
      int n;
      wait_applied(4'd1, 2000, n);
    end
    t_switch(4'd3, 600);
    t_switch(4'd1, 600);
    t_pol1_start();
    t_no_code();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule